// File: doc/BRIEF.md
# Next-PC Predictor with Target Buffer and Return Stack

This block sits in the fetch stage and predicts the address to fetch next. Each fetch address is looked up in a tagged, direct-mapped target buffer while instruction memory is read in parallel. The lookup result is produced in the same cycle. On a hit, the block supplies the target held in the matching entry. On a miss, it supplies the sequential address, which is the fetch address plus four.

Each buffer entry records what kind of control transfer it holds: a plain jump or conditional branch, a call, or a return. When a call entry hits, the address that follows the call is pushed onto a small circular return stack. When a return entry hits, the stack is popped and the popped address is used as the prediction. The stored target of a return entry is not used.

The execute stage trains the buffer. It reports the branch address, the resolved target, whether the branch was taken, and its kind. A taken branch whose entry is missing, or whose entry disagrees with the reported target or kind, is written into its slot. Any entry that previously occupied that slot is displaced.

Top module: `nextpc_predictor`

## Requirements
- R1: When fetch misses the buffer, pred_hit is 0 and pred_pc equals fetch_pc + 4.
- R2: After reset every buffer entry is invalid, so every fetch misses until training writes an entry.
- R3: A taken update (upd_taken=1) for an address with no matching entry installs that address. A later fetch of the same address then hits, and pred_pc equals the reported target.
- R4: An update with upd_taken=0 leaves the buffer unchanged, so a later fetch of that address still misses.
- R5: The slot is chosen by fetch_pc[5:2], and the remaining upper bits form the tag. Two addresses that share a slot but differ in tag do not hit on each other's entry. A taken update of one of them displaces the other.
- R6: When a fetch hits an entry of kind call (upd_kind=1), pred_pc is the stored target, and fetch_pc + 4 is pushed onto the return stack.
- R7: When a fetch hits an entry of kind return (upd_kind=2), the stack pointer steps back by one, and pred_pc is the address in the slot it then points to. That address is the most recently pushed one that has not yet been popped.
- R8: The return stack has 4 slots and a pointer that wraps. A fifth push overwrites the oldest slot. After four pops, a fifth pop returns that overwriting address again.
- R9: While fetch_valid is 0, pred_hit is 0 and pred_pc is fetch_pc + 4, and the return stack is neither pushed nor popped.
- R10: A return entry predicts from the stack and never from the target reported when it was trained.
- R11: A taken update for an address that already hits, but whose reported target differs, replaces the stored target.
- R12: upd_kind value 0, and the unused value 3, both mean a plain jump or conditional branch, which neither pushes nor pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch is performed this cycle |
| fetch_pc | input | 32 | Fetch address |
| pred_pc | output | 32 | Predicted next fetch address |
| pred_hit | output | 1 | The fetch matched a valid buffer entry |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target address |
| upd_taken | input | 1 | The branch was taken |
| upd_kind | input | 2 | 0 plain jump or conditional branch, 1 call, 2 return, 3 treated as 0 |

## Verification
Fetches are issued before training, after a not-taken report, and after a taken report. Together these separate an untouched buffer, an ignored update and an installed entry. Two addresses that share slot 0 are exercised to show that tag comparison and displacement work, and a second taken report on the same address shows that a target gets replaced. For the return stack, a single call/return pair shows that the pushed address is the one returned. Five distinct call sites followed by five returns expose the order of pops and the wrap-around overwrite. A return fetched while fetch_valid is low, placed between two calls, shows whether a hidden pop has taken place.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    localparam int PC_W      = 32;
    localparam int IDX_W     = 4;
    localparam int ENTRIES   = 1 << IDX_W;
    localparam int TAG_W     = PC_W - IDX_W - 2;
    localparam int RAS_DEPTH = 4;
    localparam int PTR_W     = $clog2(RAS_DEPTH);

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_CALL  = 2'd1,
        KIND_RET   = 2'd2
    } br_kind_e;

    typedef struct packed {
        logic     valid;
        br_kind_e kind;
        tag_t     tag;
        pc_t      target;
    } btb_entry_t;

    function automatic idx_t slot_of(pc_t pc);
        return pc[IDX_W+1:2];
    endfunction

    function automatic tag_t tag_of(pc_t pc);
        return pc[PC_W-1:IDX_W+2];
    endfunction

    function automatic br_kind_e kind_of(logic [1:0] code);
        case (code)
            2'd1:    return KIND_CALL;
            2'd2:    return KIND_RET;
            default: return KIND_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
    import nextpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pc_t        lk_pc,
    output logic       lk_match,
    output btb_entry_t lk_entry,
    input  logic       up_valid,
    input  pc_t        up_pc,
    input  pc_t        up_target,
    input  logic       up_taken,
    input  br_kind_e   up_kind
);

    btb_entry_t table_q [ENTRIES];
    btb_entry_t up_old;
    logic       up_write;

    always_comb begin
        lk_entry = table_q[slot_of(lk_pc)];
        lk_match = lk_entry.valid && (lk_entry.tag == tag_of(lk_pc));
    end

    always_comb begin
        up_old   = table_q[slot_of(up_pc)];
        up_write = up_valid && up_taken &&
                   (!up_old.valid || up_old.tag != tag_of(up_pc) ||
                    up_old.kind != up_kind ||
                    (up_kind != KIND_RET && up_old.target != up_target));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                table_q[i] <= '0;
            end
        end else if (up_write) begin
            table_q[slot_of(up_pc)] <= '{valid: 1'b1, kind: up_kind,
                                          tag: tag_of(up_pc), target: up_target};
        end
    end

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import nextpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  pc_t  push_val,
    input  logic pop,
    output pc_t  pop_val,
    output ptr_t ptr
);

    pc_t  slots_q [RAS_DEPTH];
    ptr_t ptr_q;
    ptr_t below;

    assign below   = ptr_q - ptr_t'(1);
    assign pop_val = slots_q[below];
    assign ptr     = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < RAS_DEPTH; i++) begin
                slots_q[i] <= '0;
            end
        end else if (push) begin
            slots_q[ptr_q] <= push_val;
            ptr_q          <= ptr_q + ptr_t'(1);
        end else if (pop) begin
            ptr_q <= below;
        end
    end

endmodule

// File: rtl/nextpc_predictor.sv
module nextpc_predictor
    import nextpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_pc,
    output logic [31:0] pred_pc,
    output logic        pred_hit,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic [31:0] upd_target,
    input  logic        upd_taken,
    input  logic [1:0]  upd_kind
);

    logic       lk_match;
    btb_entry_t lk_entry;
    logic       call_hit;
    logic       ret_hit;
    pc_t        seq_pc;
    pc_t        ras_top;
    ptr_t       ras_ptr;

    btb_table u_table (
        .clk       (clk),
        .rst       (rst),
        .lk_pc     (fetch_pc),
        .lk_match  (lk_match),
        .lk_entry  (lk_entry),
        .up_valid  (upd_valid),
        .up_pc     (upd_pc),
        .up_target (upd_target),
        .up_taken  (upd_taken),
        .up_kind   (kind_of(upd_kind))
    );

    assign seq_pc   = fetch_pc + pc_t'(4);
    assign pred_hit = fetch_valid && lk_match;
    assign call_hit = pred_hit && (lk_entry.kind == KIND_CALL);
    assign ret_hit  = pred_hit && (lk_entry.kind == KIND_RET);

    ret_stack u_ras (
        .clk      (clk),
        .rst      (rst),
        .push     (call_hit),
        .push_val (seq_pc),
        .pop      (ret_hit),
        .pop_val  (ras_top),
        .ptr      (ras_ptr)
    );

    always_comb begin
        if (!pred_hit)    pred_pc = seq_pc;
        else if (ret_hit) pred_pc = ras_top;
        else              pred_pc = lk_entry.target;
    end

endmodule

// File: rtl/nextpc_predictor_chk.sv
module nextpc_predictor_chk
    import nextpc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        fetch_valid,
    input logic [31:0] fetch_pc,
    input logic [31:0] pred_pc,
    input logic        pred_hit,
    input logic        call_hit,
    input logic        ret_hit,
    input ptr_t        ras_ptr
);

    a_r1_miss_is_sequential: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !pred_hit) |-> pred_pc == fetch_pc + 32'd4);

    a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> (!pred_hit && pred_pc == fetch_pc + 32'd4));

    a_r6_push_advances: assert property (@(posedge clk) disable iff (rst)
        call_hit |=> ras_ptr == ptr_t'($past(ras_ptr) + ptr_t'(1)));

    a_r7_pop_retreats: assert property (@(posedge clk) disable iff (rst)
        ret_hit |=> ras_ptr == ptr_t'($past(ras_ptr) - ptr_t'(1)));

    a_r12_ptr_holds: assert property (@(posedge clk) disable iff (rst)
        (!call_hit && !ret_hit) |=> $stable(ras_ptr));

    a_r6_one_stack_op: assert property (@(posedge clk) disable iff (rst)
        $onehot0({call_hit, ret_hit}));

endmodule

bind nextpc_predictor nextpc_predictor_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .pred_pc     (pred_pc),
    .pred_hit    (pred_hit),
    .call_hit    (call_hit),
    .ret_hit     (ret_hit),
    .ras_ptr     (ras_ptr)
);

// File: tb/sim_nextpc_predictor.sv
`timescale 1ns/1ps
module sim_nextpc_predictor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [31:0] pred_pc;
    logic        pred_hit;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [31:0] upd_target = '0;
    logic        upd_taken = 1'b0;
    logic [1:0]  upd_kind = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] pc;
        logic        hit;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    nextpc_predictor u0 (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .pred_pc(pred_pc), .pred_hit(pred_hit), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken),
        .upd_kind(upd_kind)
    );

    task automatic step(input bit fv, input logic [31:0] fpc,
                        input bit uv, input logic [31:0] upc, input logic [31:0] utgt,
                        input bit utk, input logic [1:0] uk,
                        input bit chk, input logic [31:0] epc, input bit ehit,
                        input string req);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = fpc;
        upd_valid = uv; upd_pc = upc; upd_target = utgt;
        upd_taken = utk; upd_kind = uk;
        if (chk) sb.push_back('{epc, ehit, req});
    endtask

    task automatic fetch(input logic [31:0] pc, input logic [31:0] epc,
                         input bit ehit, input string req);
        step(1, pc, 0, 0, 0, 0, 0, 1, epc, ehit, req);
    endtask

    task automatic train(input logic [31:0] pc, input logic [31:0] tgt,
                         input bit tk, input logic [1:0] k);
        step(0, 0, 1, pc, tgt, tk, k, 0, 0, 0, "");
    endtask

    // monitor: compares the expected item of this cycle ahead of the next edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_tests++;
                if (pred_pc !== e.pc || pred_hit !== e.hit) begin
                    n_fail++;
                    $display("FAIL %s: pred_pc=%h pred_hit=%b expected pred_pc=%h pred_hit=%b",
                             e.req, pred_pc, pred_hit, e.pc, e.hit);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #160000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: empty buffer after reset
        fetch(32'h100, 32'h104, 0, "R2");
        fetch(32'h90C, 32'h910, 0, "R2");
        // R4: not-taken report is ignored
        train(32'h100, 32'h200, 0, 2'd0);
        fetch(32'h100, 32'h104, 0, "R4");
        // R3: taken report installs
        train(32'h100, 32'h200, 1, 2'd0);
        fetch(32'h100, 32'h200, 1, "R3");
        // R5: same slot 0, different tag
        fetch(32'h140, 32'h144, 0, "R5");
        train(32'h140, 32'h300, 1, 2'd0);
        fetch(32'h100, 32'h104, 0, "R5");
        fetch(32'h140, 32'h300, 1, "R5");
        // R11: retarget
        train(32'h140, 32'h340, 1, 2'd0);
        fetch(32'h140, 32'h340, 1, "R11");
        // R12: kind code 3 behaves as plain
        train(32'h430, 32'h700, 1, 2'd3);
        fetch(32'h430, 32'h700, 1, "R12");
        // R6, R7, R10: one call/return pair
        train(32'h408, 32'h800, 1, 2'd1);
        train(32'h90C, 32'hDEAD, 1, 2'd2);
        fetch(32'h408, 32'h800, 1, "R6");
        fetch(32'h430, 32'h700, 1, "R12");
        fetch(32'h90C, 32'h40C, 1, "R10");
        // R8: five call sites then five returns (4-slot stack)
        train(32'h410, 32'h800, 1, 2'd1);
        train(32'h414, 32'h800, 1, 2'd1);
        train(32'h418, 32'h800, 1, 2'd1);
        train(32'h41C, 32'h800, 1, 2'd1);
        train(32'h420, 32'h800, 1, 2'd1);
        fetch(32'h410, 32'h800, 1, "R6");
        fetch(32'h414, 32'h800, 1, "R6");
        fetch(32'h418, 32'h800, 1, "R6");
        fetch(32'h41C, 32'h800, 1, "R6");
        fetch(32'h420, 32'h800, 1, "R8");
        fetch(32'h90C, 32'h424, 1, "R7");
        fetch(32'h90C, 32'h420, 1, "R7");
        fetch(32'h90C, 32'h41C, 1, "R8");
        fetch(32'h90C, 32'h418, 1, "R8");
        fetch(32'h90C, 32'h424, 1, "R8");
        // R9: idle fetches neither predict nor touch the stack
        fetch(32'h410, 32'h800, 1, "R6");
        step(0, 32'h414, 0, 0, 0, 0, 0, 1, 32'h418, 0, "R9");
        fetch(32'h414, 32'h800, 1, "R6");
        step(0, 32'h90C, 0, 0, 0, 0, 0, 1, 32'h910, 0, "R9");
        fetch(32'h90C, 32'h418, 1, "R9");
        fetch(32'h90C, 32'h414, 1, "R9");
        // R1: plain miss
        fetch(32'h1234, 32'h1238, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule